// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This block carries out the six stack-related instructions of a small 32-bit processor: single push and pop, bulk save and bulk restore of the general registers, subroutine call and subroutine return. The execute stage hands it an opcode, the index of the register that acts as stack pointer, the already resolved second operand and the current program counter. The block then runs the instruction over several cycles. In each cycle it makes one memory access and, where needed, one register-file write. It finishes with a one-cycle `done` pulse, in which it writes the final stack pointer back.

The register file is reached through one combinational read port and one write port. Memory is a single-word port whose read data is valid in the same cycle as the request. The stack grows upward. Every push moves the pointer up before it writes. Every pop reads at the pointer and then moves it down. The working pointer is kept in a private register and only written back in the final cycle. So the register that serves as stack pointer always ends up holding the pointer arithmetic, even when the same instruction also loads that register from memory.

Top module: `stack_call_seq`

## Requirements
- R1: A start is accepted only in idle and only for opcode 0x31 (call), 0x32 (return), 0x33 (push), 0x34 (pop), 0x35 (save all) or 0x36 (restore all). Any other opcode produces no memory access, no register write, no program counter load and no `done`.
- R2: Push (0x33) writes the operand to address SP+1 and leaves SP+1 in the stack-pointer register.
- R3: Pop (0x34) reads address SP into the register whose index is in operand bits [2:0], and leaves SP-1 in the stack-pointer register. If both are the same register, it ends at SP-1.
- R4: Save all (0x35) writes the start-of-instruction contents of registers 0 through 6, in that order, to addresses SP+1 through SP+7, and leaves SP+7.
- R5: Restore all (0x36) loads register 6 from SP, register 5 from SP-1, and so on down to register 0 from SP-6, and leaves SP-7 in the stack-pointer register even when it is among those loaded.
- R6: Call (0x31) writes PC+1 at SP+1 and then register 7 at SP+2, loads the program counter with the operand, and leaves SP+2.
- R7: Return (0x32) loads register 7 from SP and then the program counter from SP-1, and leaves SP-2-N in the stack-pointer register, where N is the operand.
- R8: `done` is high for exactly one cycle. It comes 2 cycles after the start edge for push and pop, 3 for call and return, and 8 for save all and restore all. A start raised while busy is ignored. Each memory access is either a write or a read, never both.
- R9: While `busy` is low there is no memory request, no register write and no program counter load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled in idle) |
| op_code | input | 8 | Instruction opcode |
| sp_reg | input | 3 | Index of the register used as stack pointer |
| operand | input | DW | Resolved second operand |
| pc_cur | input | DW | Address of the current instruction |
| rf_rd_idx | output | 3 | Register-file read index |
| rf_rd_data | input | DW | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 3 | Register-file write index |
| rf_wr_data | output | DW | Register-file write data |
| mem_we | output | 1 | Memory write request |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | DW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the request cycle |
| pc_we | output | 1 | Program counter load |
| pc_wdata | output | DW | New program counter value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final-cycle pulse |

## Verification
The hardest case to reach is a multi-register restore or a pop in which the stack-pointer register is also a destination. Here the memory load and the deferred pointer write-back hit the same register, and only the order of the two decides the result. The bench sweeps the stack-pointer index over all eight registers for every opcode, and sweeps every destination for pop. This lands the pointer on each restored slot in turn. A second start pulse injected in the middle of a bulk save covers the busy-ignore path.

// File: rtl/stack_call_pkg.sv
package stack_call_pkg;

    localparam int REG_COUNT  = 8;
    localparam int RIDX_W     = $clog2(REG_COUNT);
    localparam int SAVE_COUNT = REG_COUNT - 1;
    localparam int STEP_W     = $clog2(SAVE_COUNT);
    localparam logic [RIDX_W-1:0] FP_IDX = RIDX_W'(REG_COUNT - 1);

    typedef enum logic [7:0] {
        OP_CALL  = 8'h31,
        OP_EXIT  = 8'h32,
        OP_PUSH  = 8'h33,
        OP_POP   = 8'h34,
        OP_PUSHR = 8'h35,
        OP_POPR  = 8'h36
    } stk_op_e;

    typedef enum logic [1:0] {WS_OPND, WS_REG, WS_RET} wsrc_e;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_state_e;

    // One memory access per step; what it moves and where it lands.
    typedef struct packed {
        logic              is_push;
        wsrc_e             src;
        logic [RIDX_W-1:0] rd_idx;
        logic              rf_we;
        logic [RIDX_W-1:0] rf_idx;
        logic              pc_ld;
        logic              last;
    } step_t;

    function automatic logic is_stack_op(logic [7:0] code);
        return (code == OP_CALL) || (code == OP_EXIT) || (code == OP_PUSH) ||
               (code == OP_POP)  || (code == OP_PUSHR) || (code == OP_POPR);
    endfunction

    function automatic step_t step_decode(stk_op_e op, logic [STEP_W-1:0] cnt,
                                          logic [RIDX_W-1:0] dst);
        step_t s;
        s = '0;
        case (op)
            OP_PUSH: begin
                s.is_push = 1'b1;
                s.src     = WS_OPND;
                s.last    = 1'b1;
            end
            OP_POP: begin
                s.rf_we  = 1'b1;
                s.rf_idx = dst;
                s.last   = 1'b1;
            end
            OP_PUSHR: begin
                s.is_push = 1'b1;
                s.src     = WS_REG;
                s.rd_idx  = RIDX_W'(cnt);
                s.last    = (cnt == STEP_W'(SAVE_COUNT - 1));
            end
            OP_POPR: begin
                s.rf_we  = 1'b1;
                s.rf_idx = RIDX_W'(SAVE_COUNT - 1) - RIDX_W'(cnt);
                s.last   = (cnt == STEP_W'(SAVE_COUNT - 1));
            end
            OP_CALL: begin
                s.is_push = 1'b1;
                s.src     = (cnt == '0) ? WS_RET : WS_REG;
                s.rd_idx  = FP_IDX;
                s.last    = (cnt != '0);
            end
            OP_EXIT: begin
                s.rf_we  = (cnt == '0);
                s.rf_idx = FP_IDX;
                s.pc_ld  = (cnt != '0);
                s.last   = (cnt != '0);
            end
            default: s.last = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/stack_call_ctrl.sv
module stack_call_ctrl
    import stack_call_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              last_step,
    output seq_state_e        state,
    output logic [STEP_W-1:0] step_cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        state    <= ST_RUN;
                        step_cnt <= '0;
                    end
                end
                ST_RUN: begin
                    if (last_step) state <= ST_FIN;
                    else           step_cnt <= step_cnt + STEP_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/stack_call_ptr.sv
module stack_call_ptr #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          adv,
    input  logic          grow,
    output logic [DW-1:0] sp_q,
    output logic [DW-1:0] acc_addr
);

    logic [DW-1:0] sp_inc;
    assign sp_inc   = sp_q + DW'(1);
    // Pushes touch the slot above; pops touch the current top.
    assign acc_addr = grow ? sp_inc : sp_q;

    always_ff @(posedge clk) begin
        if (rst)       sp_q <= '0;
        else if (load) sp_q <= load_val;
        else if (adv)  sp_q <= grow ? sp_inc : sp_q - DW'(1);
    end

endmodule

// File: rtl/stack_call_seq.sv
module stack_call_seq
    import stack_call_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        op_code,
    input  logic [RIDX_W-1:0] sp_reg,
    input  logic [DW-1:0]     operand,
    input  logic [DW-1:0]     pc_cur,
    output logic [RIDX_W-1:0] rf_rd_idx,
    input  logic [DW-1:0]     rf_rd_data,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_wr_idx,
    output logic [DW-1:0]     rf_wr_data,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              pc_we,
    output logic [DW-1:0]     pc_wdata,
    output logic              busy,
    output logic              done
);

    seq_state_e        state;
    logic [STEP_W-1:0] step_cnt;
    logic              launch, run, fin;
    stk_op_e           op_q;
    logic [RIDX_W-1:0] rj_q;
    logic [DW-1:0]     opnd_q, ret_q, sp_q, acc_addr;
    step_t             st;

    assign launch = start && (state == ST_IDLE) && is_stack_op(op_code);
    assign run    = (state == ST_RUN);
    assign fin    = (state == ST_FIN);
    assign st     = step_decode(op_q, step_cnt, opnd_q[RIDX_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_PUSH;
            rj_q   <= '0;
            opnd_q <= '0;
            ret_q  <= '0;
        end else if (launch) begin
            op_q   <= stk_op_e'(op_code);
            rj_q   <= sp_reg;
            opnd_q <= operand;
            ret_q  <= pc_cur + DW'(1);
        end
    end

    stack_call_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .last_step (st.last),
        .state     (state),
        .step_cnt  (step_cnt)
    );

    stack_call_ptr #(.DW(DW)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .load_val (rf_rd_data),
        .adv      (run),
        .grow     (st.is_push),
        .sp_q     (sp_q),
        .acc_addr (acc_addr)
    );

    // In idle the read port fetches the stack pointer for capture.
    assign rf_rd_idx = (state == ST_IDLE) ? sp_reg : st.rd_idx;

    assign mem_we   = run && st.is_push;
    assign mem_re   = run && !st.is_push;
    assign mem_addr = acc_addr;

    always_comb begin
        case (st.src)
            WS_REG:  mem_wdata = rf_rd_data;
            WS_RET:  mem_wdata = ret_q;
            default: mem_wdata = opnd_q;
        endcase
    end

    // Stack pointer is written back only in the final cycle, so it wins
    // over any load of the same register earlier in the sequence.
    always_comb begin
        rf_we      = 1'b0;
        rf_wr_idx  = rj_q;
        rf_wr_data = sp_q;
        if (fin) begin
            rf_we = 1'b1;
            if (op_q == OP_EXIT) rf_wr_data = sp_q - opnd_q;
        end else if (run && st.rf_we) begin
            rf_we      = 1'b1;
            rf_wr_idx  = st.rf_idx;
            rf_wr_data = mem_rdata;
        end
    end

    always_comb begin
        pc_we    = 1'b0;
        pc_wdata = mem_rdata;
        if (fin && op_q == OP_CALL) begin
            pc_we    = 1'b1;
            pc_wdata = opnd_q;
        end else if (run && st.pc_ld) begin
            pc_we = 1'b1;
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = fin;

endmodule

// File: rtl/stack_call_chk.sv
module stack_call_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          mem_we,
    input logic          mem_re,
    input logic [DW-1:0] mem_addr,
    input logic          rf_we,
    input logic          pc_we
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_we || mem_re || rf_we || pc_we)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        done |-> (rf_we && busy)); // R8

    AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)); // R8

    AST_PUSH_ASCEND: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (!mem_we || mem_addr == $past(mem_addr) + DW'(1))); // R4

    AST_POP_DESCEND: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (!mem_re || mem_addr == $past(mem_addr) - DW'(1))); // R5

endmodule

bind stack_call_seq stack_call_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .rf_we    (rf_we),
    .pc_we    (pc_we)
);

// File: tb/stack_call_seq_bench.sv
`timescale 1ns/1ps
module stack_call_seq_bench;
    import stack_call_pkg::*;

    localparam int DW   = 32;
    localparam int MEMN = 256;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, start;
    logic [7:0]    op_code;
    logic [2:0]    sp_reg;
    logic [DW-1:0] operand, pc_cur;
    logic [2:0]    rf_rd_idx, rf_wr_idx;
    logic [DW-1:0] rf_rd_data, rf_wr_data;
    logic          rf_we, mem_we, mem_re, pc_we, busy, done;
    logic [DW-1:0] mem_addr, mem_wdata, mem_rdata, pc_wdata;

    logic [DW-1:0] regs [8];
    logic [DW-1:0] mem  [MEMN];
    logic [DW-1:0] pc_reg;
    logic [DW-1:0] er   [8];
    logic [DW-1:0] em   [MEMN];
    logic [DW-1:0] ep;

    int n_chk = 0, n_bad = 0;
    int n_memw = 0, n_rfw = 0, n_done = 0, n_pcw = 0;

    assign rf_rd_data = regs[rf_rd_idx];
    assign mem_rdata  = mem[mem_addr[7:0]];

    stack_call_seq #(.DW(DW)) u_stack_call_seq (
        .clk(clk), .rst(rst), .start(start), .op_code(op_code), .sp_reg(sp_reg),
        .operand(operand), .pc_cur(pc_cur), .rf_rd_idx(rf_rd_idx),
        .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_wr_idx(rf_wr_idx),
        .rf_wr_data(rf_wr_data), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .busy(busy), .done(done)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Environment: commit the current cycle's requests (called at negedge).
    task automatic apply_env();
        if (mem_we) begin mem[mem_addr[7:0]] = mem_wdata; n_memw++; end
        if (rf_we)  begin regs[rf_wr_idx] = rf_wr_data; n_rfw++; end
        if (pc_we)  begin pc_reg = pc_wdata; n_pcw++; end
        if (done)   n_done++;
    endtask

    task automatic prep(input int rj, input logic [DW-1:0] sp, input int seed);
        for (int i = 0; i < 8; i++) regs[i] = 32'h0100_0000 * (i + 1) + DW'(seed);
        regs[rj] = sp;
        for (int a = 0; a < MEMN; a++) mem[a] = (DW'(a) * 32'd977) ^ (32'hC000_0000 + DW'(seed));
        pc_reg = 32'h0000_DEAD;
        for (int i = 0; i < 8; i++) er[i] = regs[i];
        for (int a = 0; a < MEMN; a++) em[a] = mem[a];
        ep = pc_reg;
    endtask

    task automatic cmp_state(input string req);
        int bad_r = -1, bad_m = -1;
        for (int i = 0; i < 8; i++) if (bad_r < 0 && regs[i] !== er[i]) bad_r = i;
        for (int a = 0; a < MEMN; a++) if (bad_m < 0 && mem[a] !== em[a]) bad_m = a;
        if (bad_r >= 0) chk(req, $sformatf("reg%0d", bad_r), regs[bad_r], er[bad_r]);
        else            chk(req, "regs", 0, 0);
        if (bad_m >= 0) chk(req, $sformatf("mem[%0d]", bad_m), mem[bad_m], em[bad_m]);
        else            chk(req, "mem", 0, 0);
        chk(req, "pc", pc_reg, ep);
    endtask

    // Called at a negedge; returns at the negedge after completion.
    task automatic run_op(input logic [7:0] op, input int rj, input logic [DW-1:0] opnd,
                          input logic [DW-1:0] pc, input int exp_lat, input bit glitch,
                          input string req);
        int lat = 0;
        int d0 = n_done;
        op_code = op; sp_reg = 3'(rj); operand = opnd; pc_cur = pc; start = 1'b1;
        while (lat < 40) begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (glitch && lat == 3) begin
                op_code = OP_PUSH; operand = 32'h7777; start = 1'b1;
            end
            apply_env();
            if (done) break;
        end
        start = 1'b0;
        chk("R8", $sformatf("%s latency", req), DW'(lat), DW'(exp_lat));
        @(negedge clk);
        apply_env();
        chk("R8", $sformatf("%s done count", req), DW'(n_done - d0), 1);
        chk("R9", $sformatf("%s busy after", req), DW'(busy), 0);
        cmp_state(req);
    endtask

    initial begin
        logic [DW-1:0] sp;
        int mw0, rw0, dn0, pw0;
        rst = 1'b1; start = 1'b0; op_code = '0; sp_reg = '0; operand = '0; pc_cur = '0;
        prep(0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R9", "reset busy", DW'(busy), 0);
        chk("R9", "reset done", DW'(done), 0);
        chk("R9", "reset requests", DW'({mem_we, mem_re, rf_we, pc_we}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: foreign opcodes are ignored
        foreach (em[k]) em[k] = em[k];
        for (int t = 0; t < 5; t++) begin
            logic [7:0] bad_op;
            bad_op = (t == 0) ? 8'h11 : (t == 1) ? 8'h00 : (t == 2) ? 8'h30 :
                     (t == 3) ? 8'h37 : 8'h70;
            prep(6, 32'd50, t);
            mw0 = n_memw; rw0 = n_rfw; dn0 = n_done; pw0 = n_pcw;
            op_code = bad_op; sp_reg = 3'd6; operand = 32'h5; start = 1'b1;
            @(negedge clk); apply_env(); start = 1'b0;
            repeat (4) begin @(negedge clk); apply_env(); end
            chk("R1", $sformatf("op %h activity", bad_op),
                DW'(n_memw - mw0 + n_rfw - rw0 + n_done - dn0 + n_pcw - pw0), 0);
            chk("R1", $sformatf("op %h busy", bad_op), DW'(busy), 0);
        end

        // R2: push
        for (int rj = 0; rj < 8; rj++) begin
            for (int v = 0; v < 2; v++) begin
                sp = (v == 0) ? 32'd20 : 32'd100;
                prep(rj, sp, rj * 3 + v);
                em[sp + 1] = 32'hABC0_0000 + DW'(rj);
                er[rj] = sp + 1;
                run_op(OP_PUSH, rj, 32'hABC0_0000 + DW'(rj), 32'h10, 2, 1'b0, "R2");
            end
        end

        // R3: pop, every pointer register against every destination
        for (int rj = 0; rj < 8; rj++) begin
            for (int ri = 0; ri < 8; ri++) begin
                sp = 32'd60 + DW'(ri);
                prep(rj, sp, rj * 8 + ri);
                er[ri] = em[sp];
                er[rj] = sp - 1;
                run_op(OP_POP, rj, 32'h5500 | DW'(ri), 32'h10, 2, 1'b0, "R3");
            end
        end

        // R4: save all
        for (int rj = 0; rj < 8; rj++) begin
            sp = 32'd30 + DW'(rj);
            prep(rj, sp, 40 + rj);
            for (int k = 0; k < 7; k++) em[sp + 1 + DW'(k)] = er[k];
            er[rj] = sp + 7;
            run_op(OP_PUSHR, rj, 32'h0, 32'h10, 8, 1'b0, "R4");
        end

        // R5: restore all, pointer register may be one of the restored ones
        for (int rj = 0; rj < 8; rj++) begin
            sp = 32'd120 + DW'(rj);
            prep(rj, sp, 60 + rj);
            for (int k = 0; k < 7; k++) er[6 - k] = em[sp - DW'(k)];
            er[rj] = sp - 7;
            run_op(OP_POPR, rj, 32'h0, 32'h10, 8, 1'b0, "R5");
        end

        // R6: call
        for (int rj = 0; rj < 8; rj++) begin
            sp = 32'd40 + DW'(rj);
            prep(rj, sp, 80 + rj);
            em[sp + 1] = 32'h200 + DW'(rj) + 1;
            em[sp + 2] = er[7];
            ep = 32'h3000 + DW'(rj);
            er[rj] = sp + 2;
            run_op(OP_CALL, rj, 32'h3000 + DW'(rj), 32'h200 + DW'(rj), 3, 1'b0, "R6");
        end

        // R7: return with 0..3 parameters
        for (int rj = 0; rj < 8; rj++) begin
            for (int n = 0; n < 4; n++) begin
                sp = 32'd150 + DW'(rj);
                prep(rj, sp, 100 + rj * 4 + n);
                er[7] = em[sp];
                ep    = em[sp - 1];
                er[rj] = sp - 2 - DW'(n);
                run_op(OP_EXIT, rj, DW'(n), 32'h10, 3, 1'b0, "R7");
            end
        end

        // R8: a start while busy is ignored
        sp = 32'd70;
        prep(6, sp, 200);
        for (int k = 0; k < 7; k++) em[sp + 1 + DW'(k)] = er[k];
        er[6] = sp + 7;
        run_op(OP_PUSHR, 6, 32'h0, 32'h10, 8, 1'b1, "R8 busy-start");
        mw0 = n_memw; rw0 = n_rfw;
        repeat (4) begin @(negedge clk); apply_env(); end
        chk("R8", "no late activity", DW'(n_memw - mw0 + n_rfw - rw0), 0);

        summary();
        $finish;
    end

endmodule